// File: doc/BRIEF.md
# JTAG Test Access Port Controller

This block is a boundary-scan test access port. It follows the sixteen-state TAP state machine, which TMS steers on each rising edge of TCK. It holds a 10-bit instruction register, and the decoded instruction selects one data register to sit between TDI and TDO. The candidates are a single-bit bypass stage, a 32-bit identification word, a 32-bit user word, and a boundary register of parameterised length. TDO is launched on the falling edge of TCK, together with an enable for the pad driver.

Towards the boundary cells, the block supplies three strobes: capture, shift and update. It also drives the parallel pattern held in its update stage. Two mode flags go to the pad ring. One forces the boundary pattern onto the output pins while the external-test instruction is active. The other floats every I/O pin while the high-impedance instruction is active.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: The state register moves through the standard sixteen TAP states on the rising edge of TCK under TMS. Five consecutive rising edges with TMS high reach Test-Logic-Reset from any state. Pause-DR and Exit2-DR hold the data register without shifting.
- R2: A low level on rst_ni at once forces Test-Logic-Reset and makes the instruction IDCODE. It also drops tdo_oe_o, extest_o and highz_o and clears bsr_data_o. Test-Logic-Reset reached through TMS also restores IDCODE.
- R3: The instruction register is 10 bits wide and is shifted least significant bit first. Capture-IR loads 10'b00_0000_0001. A new instruction takes effect only when Update-IR is left.
- R4: The instruction codes are as follows:
  - EXTEST = 10'h00F
  - SAMPLE/PRELOAD = 10'h005
  - IDCODE = 10'h006
  - USERCODE = 10'h007
  - HIGHZ = 10'h00B
  - BYPASS = 10'h3FF
  
  Every other code acts as BYPASS.
- R5: BYPASS, HIGHZ and unknown codes select a single stage. That stage captures 0 and delays TDI by one TCK.
- R6: IDCODE selects a 32-bit word taken from the IDCODE_VAL parameter, with bit 0 forced to 1. The word is shifted out LSB first.
- R7: USERCODE selects a 32-bit word taken from the USERCODE_VAL parameter, which defaults to all ones.
- R8: EXTEST and SAMPLE/PRELOAD select a BSR_LEN-bit register. It loads pin_i at Capture-DR and shifts LSB first. Its content moves to bsr_data_o at Update-DR. Under any other instruction, bsr_data_o is unchanged.
- R9: extest_o is high exactly while EXTEST is the current instruction. highz_o is high exactly while HIGHZ is the current instruction.
- R10: TDO and tdo_oe_o change on the falling edge of TCK. tdo_oe_o is high only in Shift-DR and Shift-IR.
- R11: bsr_capture_o, bsr_shift_o and bsr_update_o are high only in Capture-DR, Shift-DR and Update-DR, and only under a boundary instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, launched on the falling edge |
| tdo_oe_o | output | 1 | Enable for the TDO pad driver |
| pin_i | input | BSR_LEN | Pin states captured by the boundary register |
| bsr_data_o | output | BSR_LEN | Boundary pattern held in the update stage |
| bsr_capture_o | output | 1 | Boundary capture strobe |
| bsr_shift_o | output | 1 | Boundary shift strobe |
| bsr_update_o | output | 1 | Boundary update strobe |
| extest_o | output | 1 | Force the boundary pattern onto the output pins |
| highz_o | output | 1 | Float all I/O pins |

## Verification
Some behaviour is checked by properties on every TCK edge:
- the five-ones path into Test-Logic-Reset;
- the Capture-IR value and the instruction holding outside Update-IR;
- the one-cycle bypass delay and the forced identification LSB;
- the update stage holding between update strobes;
- the output enable tracking the shift states.

Other behaviour only the bench scenarios show. This covers the bit order and content of every data register under each opcode, unknown codes falling back to bypass, and the pause and resume of a shift. It also covers the boundary pattern reaching bsr_data_o, and the asynchronous reset clearing the mode flags mid-instruction.

// File: rtl/jtag_tap_pkg.sv
`timescale 1ns/1ps
package jtag_tap_pkg;

  localparam int IR_W = 10;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    DR_BYPASS, DR_IDCODE, DR_USER, DR_BOUND
  } dr_sel_e;

  localparam logic [IR_W-1:0] OPC_SAMPLE  = 10'b00_0000_0101;
  localparam logic [IR_W-1:0] OPC_EXTEST  = 10'b00_0000_1111;
  localparam logic [IR_W-1:0] OPC_BYPASS  = 10'b11_1111_1111;
  localparam logic [IR_W-1:0] OPC_USER    = 10'b00_0000_0111;
  localparam logic [IR_W-1:0] OPC_IDCODE  = 10'b00_0000_0110;
  localparam logic [IR_W-1:0] OPC_HIGHZ   = 10'b00_0000_1011;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 10'b00_0000_0001;

endpackage

// File: rtl/jtag_tap_fsm.sv
`timescale 1ns/1ps
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // run of consecutive TMS highs, saturating at five
  logic [2:0] hi_run_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)              hi_run_q <= 3'd0;
    else if (!tms_i)          hi_run_q <= 3'd0;
    else if (hi_run_q != 3'd5) hi_run_q <= hi_run_q + 3'd1;
  end

  p_five_ones_tlr_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (hi_run_q == 3'd5) |-> (state_q == ST_TLR));

  p_tlr_leave_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_TLR && !tms_i) |=> (state_q == ST_RTI));

endmodule

// File: rtl/jtag_tap_ir.sv
`timescale 1ns/1ps
module jtag_tap_ir
  import jtag_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  tap_state_e state_i,
  input  logic       tdi_i,
  output logic       ir_tdo_o,
  output dr_sel_e    sel_o,
  output logic       extest_o,
  output logic       highz_o
);

  logic [IR_W-1:0] ir_sh_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_sh_q <= IR_CAPTURE;
      ir_q    <= OPC_IDCODE;
    end else begin
      unique case (state_i)
        ST_TLR:    ir_q    <= OPC_IDCODE;
        ST_CAP_IR: ir_sh_q <= IR_CAPTURE;
        ST_SH_IR:  ir_sh_q <= {tdi_i, ir_sh_q[IR_W-1:1]};
        ST_UPD_IR: ir_q    <= ir_sh_q;
        default: ;
      endcase
    end
  end

  assign ir_tdo_o = ir_sh_q[0];

  always_comb begin
    sel_o    = DR_BYPASS;
    extest_o = 1'b0;
    highz_o  = 1'b0;
    unique case (ir_q)
      OPC_EXTEST: begin sel_o = DR_BOUND; extest_o = 1'b1; end
      OPC_SAMPLE: sel_o = DR_BOUND;
      OPC_IDCODE: sel_o = DR_IDCODE;
      OPC_USER:   sel_o = DR_USER;
      OPC_HIGHZ:  highz_o = 1'b1;
      default:    sel_o = DR_BYPASS;
    endcase
  end

  p_ir_capture_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_CAP_IR) |=> (ir_sh_q == IR_CAPTURE));

  p_ir_hold_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(state_i inside {ST_UPD_IR, ST_TLR}) |=> $stable(ir_q));

  p_highz_bypass_r9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    highz_o |-> (sel_o == DR_BYPASS && !extest_o));

endmodule

// File: rtl/jtag_tap_dr.sv
`timescale 1ns/1ps
module jtag_tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int          BSR_LEN      = 24,
  parameter logic [31:0] IDCODE_VAL   = 32'h0A5C_30DD,
  parameter logic [31:0] USERCODE_VAL = '1
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  tap_state_e         state_i,
  input  dr_sel_e            sel_i,
  input  logic               tdi_i,
  input  logic [BSR_LEN-1:0] pin_i,
  output logic               dr_tdo_o,
  output logic [BSR_LEN-1:0] bsr_data_o,
  output logic               bsr_capture_o,
  output logic               bsr_shift_o,
  output logic               bsr_update_o
);

  localparam int          WORD_W   = 32;
  localparam logic [31:0] ID_FIXED = {IDCODE_VAL[31:1], 1'b1};

  logic               byp_q;
  logic [WORD_W-1:0]  word_q;
  logic [BSR_LEN-1:0] bsr_sh_q, bsr_upd_q, bsr_next;

  generate
    if (BSR_LEN == 1) begin : g_bsr_single
      assign bsr_next = tdi_i;
    end else begin : g_bsr_chain
      assign bsr_next = {tdi_i, bsr_sh_q[BSR_LEN-1:1]};
    end
  endgenerate

  assign bsr_capture_o = (state_i == ST_CAP_DR) && (sel_i == DR_BOUND);
  assign bsr_shift_o   = (state_i == ST_SH_DR)  && (sel_i == DR_BOUND);
  assign bsr_update_o  = (state_i == ST_UPD_DR) && (sel_i == DR_BOUND);

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q    <= 1'b0;
      word_q   <= '0;
      bsr_sh_q <= '0;
    end else if (state_i == ST_CAP_DR) begin
      unique case (sel_i)
        DR_BYPASS: byp_q    <= 1'b0;
        DR_IDCODE: word_q   <= ID_FIXED;
        DR_USER:   word_q   <= USERCODE_VAL;
        DR_BOUND:  bsr_sh_q <= pin_i;
        default: ;
      endcase
    end else if (state_i == ST_SH_DR) begin
      unique case (sel_i)
        DR_BYPASS:         byp_q    <= tdi_i;
        DR_IDCODE, DR_USER: word_q  <= {tdi_i, word_q[WORD_W-1:1]};
        DR_BOUND:          bsr_sh_q <= bsr_next;
        default: ;
      endcase
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)           bsr_upd_q <= '0;
    else if (bsr_update_o) bsr_upd_q <= bsr_sh_q;
  end

  assign bsr_data_o = bsr_upd_q;

  always_comb begin
    unique case (sel_i)
      DR_IDCODE, DR_USER: dr_tdo_o = word_q[0];
      DR_BOUND:           dr_tdo_o = bsr_sh_q[0];
      default:            dr_tdo_o = byp_q;
    endcase
  end

  p_bypass_delay_r5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_SH_DR && sel_i == DR_BYPASS) |=> (byp_q == $past(tdi_i)));

  p_idcode_lsb_r6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_CAP_DR && sel_i == DR_IDCODE) |=> word_q[0]);

  p_upd_hold_r8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !bsr_update_o |=> $stable(bsr_data_o));

  p_capture_next_r11: assert property (@(posedge tck_i) disable iff (!rst_ni)
    bsr_capture_o |=> (state_i inside {ST_SH_DR, ST_EX1_DR}));

endmodule

// File: rtl/jtag_tap_ctrl.sv
`timescale 1ns/1ps
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter int          BSR_LEN      = 24,
  parameter logic [31:0] IDCODE_VAL   = 32'h0A5C_30DD,
  parameter logic [31:0] USERCODE_VAL = '1
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               tms_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  output logic               tdo_oe_o,
  input  logic [BSR_LEN-1:0] pin_i,
  output logic [BSR_LEN-1:0] bsr_data_o,
  output logic               bsr_capture_o,
  output logic               bsr_shift_o,
  output logic               bsr_update_o,
  output logic               extest_o,
  output logic               highz_o
);

  tap_state_e state;
  dr_sel_e    sel;
  logic       ir_tdo, dr_tdo;

  jtag_tap_fsm u_fsm (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (state)
  );

  jtag_tap_ir u_ir (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .tdi_i    (tdi_i),
    .ir_tdo_o (ir_tdo),
    .sel_o    (sel),
    .extest_o (extest_o),
    .highz_o  (highz_o)
  );

  jtag_tap_dr #(
    .BSR_LEN      (BSR_LEN),
    .IDCODE_VAL   (IDCODE_VAL),
    .USERCODE_VAL (USERCODE_VAL)
  ) u_dr (
    .tck_i         (tck_i),
    .rst_ni        (rst_ni),
    .state_i       (state),
    .sel_i         (sel),
    .tdi_i         (tdi_i),
    .pin_i         (pin_i),
    .dr_tdo_o      (dr_tdo),
    .bsr_data_o    (bsr_data_o),
    .bsr_capture_o (bsr_capture_o),
    .bsr_shift_o   (bsr_shift_o),
    .bsr_update_o  (bsr_update_o)
  );

  // launch on the falling edge so the next device samples a settled value
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_o    <= 1'b0;
      tdo_oe_o <= 1'b0;
    end else begin
      tdo_o    <= (state == ST_SH_IR) ? ir_tdo : dr_tdo;
      tdo_oe_o <= (state == ST_SH_IR) || (state == ST_SH_DR);
    end
  end

  p_oe_in_shift_r10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o == (state inside {ST_SH_DR, ST_SH_IR}));

endmodule

// File: tb/sim_jtag_tap_ctrl.sv
`timescale 1ns/1ps
module sim_jtag_tap_ctrl;

  localparam int          BL     = 12;
  localparam logic [31:0] ID_RAW = 32'h2B17_C0DE;
  localparam logic [31:0] ID_EXP = 32'h2B17_C0DF;
  localparam logic [31:0] UC_EXP = 32'hFFFF_FFFF;
  localparam int          NBITS  = 48;

  // opcode, kind (0 bypass, 1 id, 2 user, 3 boundary), highz, extest
  localparam logic [9:0] T_OP   [7] = '{10'h005, 10'h00F, 10'h3FF, 10'h007, 10'h006, 10'h00B, 10'h2AA};
  localparam int         T_KIND [7] = '{3, 3, 0, 2, 1, 0, 0};
  localparam logic       T_HZ   [7] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic       T_EX   [7] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

  logic          tck = 1'b0;
  logic          rst_n, tms, tdi;
  logic [BL-1:0] pins;
  logic          tdo, tdo_oe, cap_s, sh_s, upd_s, extest, highz;
  logic [BL-1:0] bsr_data;

  int total = 0;
  int bad   = 0;
  logic oe_bad = 1'b0;

  always #2 tck = ~tck;

  jtag_tap_ctrl #(.BSR_LEN(BL), .IDCODE_VAL(ID_RAW)) u0 (
    .tck_i (tck), .rst_ni (rst_n), .tms_i (tms), .tdi_i (tdi),
    .tdo_o (tdo), .tdo_oe_o (tdo_oe), .pin_i (pins), .bsr_data_o (bsr_data),
    .bsr_capture_o (cap_s), .bsr_shift_o (sh_s), .bsr_update_o (upd_s),
    .extest_o (extest), .highz_o (highz)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [9:0] op, output logic [9:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 10; i++) begin
      cap[i] = tdo;
      if (!tdo_oe) oe_bad = 1'b1;
      step(i == 9, op[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] pat, output logic [63:0] got);
    got = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      got[i] = tdo;
      if (!tdo_oe) oe_bad = 1'b1;
      step(i == n - 1, pat[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [63:0] expect_out(int len, logic [63:0] c, logic [63:0] p);
    logic [63:0] e = '0;
    for (int i = 0; i < NBITS; i++) e[i] = (i < len) ? c[i] : p[i - len];
    return e;
  endfunction

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [9:0]    cap;
    logic [63:0]   got, pat, exp;
    logic [BL-1:0] last_upd;
    int            len;
    logic [63:0]   cv;

    rst_n = 1'b0; tms = 1'b1; tdi = 1'b0; pins = '0;
    repeat (3) @(negedge tck);
    #1;
    // R2: reset state
    chk(!tdo_oe && !extest && !highz, "R2", {61'd0, tdo_oe, extest, highz}, 64'd0);
    chk(bsr_data == '0, "R2", 64'(bsr_data), 64'd0);
    rst_n = 1'b1;
    step(0, 0);
    chk(!tdo_oe, "R10", 64'(tdo_oe), 64'd0);
    // R2/R6: IDCODE is the instruction after reset
    pat = 64'h0000_9C3A_5E71_B2D4;
    shift_dr(NBITS, pat, got);
    exp = expect_out(32, 64'(ID_EXP), pat);
    chk(got[47:0] == exp[47:0], "R6", got, exp);

    last_upd = '0;
    for (int v = 0; v < 7; v++) begin
      pins = 12'hA5C ^ BL'(v * 37);
      pat  = 64'h0000_9C3A_5E71_B2D4 ^ 64'(v * 32'h0013_579B);
      load_ir(T_OP[v], cap);
      chk(cap == 10'h001, "R3", 64'(cap), 64'h1);
      chk(extest == T_EX[v] && highz == T_HZ[v], "R9",
          {62'd0, extest, highz}, {62'd0, T_EX[v], T_HZ[v]});
      shift_dr(NBITS, pat, got);
      unique case (T_KIND[v])
        1: begin len = 32; cv = 64'(ID_EXP); end
        2: begin len = 32; cv = 64'(UC_EXP); end
        3: begin len = BL; cv = 64'(pins);   end
        default: begin len = 1; cv = '0; end
      endcase
      exp = expect_out(len, cv, pat);
      if (T_KIND[v] == 0)      chk(got[47:0] == exp[47:0], "R5", got, exp);
      else if (T_KIND[v] == 1) chk(got[47:0] == exp[47:0], "R4", got, exp);
      else if (T_KIND[v] == 2) chk(got[47:0] == exp[47:0], "R7", got, exp);
      else                     chk(got[47:0] == exp[47:0], "R8", got, exp);
      if (T_KIND[v] == 3) last_upd = pat[NBITS-1 -: BL];
      chk(bsr_data == last_upd, "R8", 64'(bsr_data), 64'(last_upd));
      chk(!tdo_oe && !cap_s && !sh_s && !upd_s, "R11",
          {60'd0, tdo_oe, cap_s, sh_s, upd_s}, 64'd0);
    end
    chk(!oe_bad, "R10", 64'(oe_bad), 64'd0);

    // R1: five TMS highs from mid Shift-DR return to IDCODE
    load_ir(10'h007, cap);
    step(1, 0); step(0, 0); step(0, 0); step(0, 1); step(0, 1);
    repeat (5) step(1, 0);
    chk(!tdo_oe && !extest && !highz, "R1", {61'd0, tdo_oe, extest, highz}, 64'd0);
    step(0, 0);
    pat = 64'h0000_0F0F_3C3C_A55A;
    shift_dr(NBITS, pat, got);
    exp = expect_out(32, 64'(ID_EXP), pat);
    chk(got[47:0] == exp[47:0], "R1", got, exp);

    // R1: pause and resume inside a data shift
    step(1, 0); step(0, 0); step(0, 0);
    got = '0;
    for (int i = 0; i < 4; i++) begin
      got[i] = tdo;
      step(i == 3, 0);
    end
    step(0, 0); step(0, 0);
    chk(!tdo_oe, "R10", 64'(tdo_oe), 64'd0);
    step(1, 0); step(0, 0);
    got[4] = tdo;
    chk(got[4:0] == ID_EXP[4:0], "R1", 64'(got[4:0]), 64'(ID_EXP[4:0]));
    step(1, 0); step(1, 0); step(0, 0);

    // R2: asynchronous reset drops EXTEST at once
    load_ir(10'h00F, cap);
    chk(extest, "R9", 64'(extest), 64'd1);
    rst_n = 1'b0;
    #0.5;
    chk(!extest && !tdo_oe, "R2", {62'd0, extest, tdo_oe}, 64'd0);
    @(negedge tck); #1;
    rst_n = 1'b1;
    step(0, 0);
    shift_dr(NBITS, pat, got);
    exp = expect_out(32, 64'(ID_EXP), pat);
    chk(got[47:0] == exp[47:0], "R2", got, exp);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule